// File: doc/BRIEF.md
# Secure Peripheral Access Gate

This block stands between one upstream bus master and up to sixteen downstream peripheral ports. Both sides use an APB-style handshake with one select line per port. Every transfer carries two attribute bits: a secure flag and an unprivileged flag. When the setup phase of a transfer begins, the gate checks the selected port's configuration. It then either forwards the transfer to that port unchanged, or blocks it locally and answers the master itself.

The configuration comes in on plain input wires and is not reached over the bus. Each port has one bit that marks it as non-secure and one bit that permits unprivileged access. A build-time mask turns off the security check on chosen ports. For a blocked transfer, one input selects the response: either an error, or a silent completion in which a read returns zero and a write is dropped. Every blocked transfer also sets a sticky status flag, and that flag drives a level interrupt. The interrupt has an enable input and a clear input.

The timing is fixed for a given path. A forwarded transfer raises the upstream ready three cycles after the setup cycle, plus one cycle for each wait state the downstream port inserts. A blocked transfer always takes three cycles, the same as a forwarded transfer to a port that adds no wait states.

Top module: `secure_access_gate`

## Requirements
- R1: After synchronous reset, up_pready, up_pslverr, dn_psel, dn_penable and irq are all 0, and the captured blocked-response mode is silent.
- R2: When the mask bit of the selected port is 0, a transfer is blocked if its secure flag equals that port's cfg_nonsec bit (1 = non-secure port). This blocks a secure transfer to a non-secure port and a non-secure transfer to a secure port.
- R3: A port whose NONSEC_MASK bit is 1 never blocks a transfer on the security check, whatever the secure flag and cfg_nonsec are.
- R4: A transfer with up_puser = 1 (unprivileged) is blocked when the selected port's cfg_ap bit is 0. This applies whether or not the port's mask bit is set.
- R5: When cfg_err_resp is 1 at the start of a blocked transfer, the transfer completes with up_pslverr = 1.
- R6: When cfg_err_resp is 0 at the start of a blocked transfer, it completes with up_pslverr = 0. A blocked read returns all-zero data, and a blocked write leaves the port's contents untouched.
- R7: A blocked transfer never asserts any dn_psel bit or dn_penable. Its up_pready pulses for one cycle, three cycles after the setup cycle.
- R8: A permitted transfer reaches only the selected port with its address, write data, direction, size code (0..3 meaning 1, 2, 4 or 8 bytes, little-endian), secure flag and unprivileged flag unchanged. The port's read data and error are returned upstream, and up_pready rises 3 + W cycles after the setup cycle, where W is the number of wait states the port inserts.
- R9: A blocked transfer sets a sticky status flag, and irq equals that flag ANDed with irq_en.
- R10: While irq_clr is high, the status flag is held at 0, and a blocked transfer whose setup cycle falls in that window does not set it.
- R11: The configuration inputs (cfg_nonsec, cfg_ap, cfg_err_resp) are sampled at the clock edge that ends the setup cycle. A change during the rest of the transfer affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nonsec | input | NUM_PORTS | Per-port security setting, 1 = non-secure port |
| cfg_ap | input | NUM_PORTS | Per-port unprivileged-access permission, 1 = allowed |
| cfg_err_resp | input | 1 | Blocked response mode, 1 = error, 0 = silent |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Interrupt clear, level sensitive |
| up_psel | input | NUM_PORTS | Upstream one-hot port select |
| up_penable | input | 1 | Upstream access phase |
| up_pwrite | input | 1 | Upstream direction, 1 = write |
| up_paddr | input | ADDR_W | Upstream address |
| up_pwdata | input | DATA_W | Upstream write data |
| up_psize | input | 2 | Size code, 2^n bytes |
| up_psecure | input | 1 | Secure transfer flag |
| up_puser | input | 1 | Unprivileged transfer flag |
| up_prdata | output | DATA_W | Read data to the master |
| up_pready | output | 1 | Transfer complete |
| up_pslverr | output | 1 | Error response |
| dn_psel | output | NUM_PORTS | Downstream one-hot select |
| dn_penable | output | 1 | Downstream access phase |
| dn_pwrite | output | 1 | Forwarded direction |
| dn_paddr | output | ADDR_W | Forwarded address |
| dn_pwdata | output | DATA_W | Forwarded write data |
| dn_psize | output | 2 | Forwarded size code |
| dn_psecure | output | 1 | Forwarded secure flag |
| dn_puser | output | 1 | Forwarded unprivileged flag |
| dn_prdata | input | NUM_PORTS*DATA_W | Read data of every port, port i at slice i |
| dn_pready | input | NUM_PORTS | Per-port ready |
| dn_pslverr | input | NUM_PORTS | Per-port error |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land on the same clock edge: a blocked transfer trying to set the interrupt flag, and the clear input forcing that flag down. The bench holds irq_clr high across the setup cycle of a blocked transfer and then releases it. The interrupt must stay low afterwards, because the clear wins that edge. A cycle-by-cycle behavioural model of the flag, fed the bench's own block prediction, is compared with irq on every clock. That comparison also covers the sticky behaviour and the effect of irq_en.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DSETUP,
    ST_DACCESS,
    ST_HOLD1,
    ST_HOLD2,
    ST_RESP
  } seq_state_t;

  localparam int SIZE_W = 2;

  typedef struct packed {
    logic              write;
    logic              secure;
    logic              unpriv;
    logic [SIZE_W-1:0] size;
  } xfer_attr_t;
endpackage

// File: rtl/sag_port_check.sv
`timescale 1ns/1ps
module sag_port_check #(
  parameter int                   NUM_PORTS   = 16,
  parameter logic [NUM_PORTS-1:0] NONSEC_MASK = '0
) (
  input  logic [NUM_PORTS-1:0] sel_oh,
  input  logic [NUM_PORTS-1:0] cfg_nonsec,
  input  logic [NUM_PORTS-1:0] cfg_ap,
  input  logic                 secure,
  input  logic                 unpriv,
  output logic                 blocked
);
  logic [NUM_PORTS-1:0] sec_fail;
  logic [NUM_PORTS-1:0] priv_fail;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    if (NONSEC_MASK[g]) begin : g_waived
      assign sec_fail[g] = 1'b0;
    end else begin : g_checked
      assign sec_fail[g] = (secure == cfg_nonsec[g]);
    end
    assign priv_fail[g] = unpriv & ~cfg_ap[g];
  end

  assign blocked = |(sel_oh & (sec_fail | priv_fail));
endmodule

// File: rtl/sag_irq_ctrl.sv
`timescale 1ns/1ps
module sag_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic block_evt,
  input  logic irq_clr,
  input  logic irq_en,
  output logic irq
);
  logic status_q;

  always_ff @(posedge clk) begin
    if (rst)            status_q <= 1'b0;
    else if (irq_clr)   status_q <= 1'b0;
    else if (block_evt) status_q <= 1'b1;
  end

  assign irq = status_q & irq_en;

  // R10: a clear seen on the previous edge leaves the flag low
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
    $past(irq_clr) |-> !status_q);

  // R9: the flag only rises after a blocked transfer
  p_set_by_block_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(block_evt));
endmodule

// File: rtl/sag_sequencer.sv
`timescale 1ns/1ps
module sag_sequencer
  import sag_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PORTS-1:0]  up_psel,
  input  logic                  up_penable,
  input  logic                  up_pwrite,
  input  logic [ADDR_W-1:0]     up_paddr,
  input  logic [DATA_W-1:0]     up_pwdata,
  input  logic [SIZE_W-1:0]     up_psize,
  input  logic                  up_psecure,
  input  logic                  up_puser,
  input  logic                  blocked,
  input  logic                  cfg_err_resp,
  output logic                  start,
  output logic [DATA_W-1:0]     up_prdata,
  output logic                  up_pready,
  output logic                  up_pslverr,
  output logic [NUM_PORTS-1:0]  dn_psel,
  output logic                  dn_penable,
  output logic                  dn_pwrite,
  output logic [ADDR_W-1:0]     dn_paddr,
  output logic [DATA_W-1:0]     dn_pwdata,
  output logic [SIZE_W-1:0]     dn_psize,
  output logic                  dn_psecure,
  output logic                  dn_puser,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_prdata,
  input  logic [NUM_PORTS-1:0]  dn_pready,
  input  logic [NUM_PORTS-1:0]  dn_pslverr
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  seq_state_t           state_q;
  logic [IDX_W-1:0]     sel_idx;
  logic [IDX_W-1:0]     idx_q;
  logic                 err_q;
  logic                 blk_q;
  xfer_attr_t           attr_q;
  logic [NUM_PORTS-1:0] dn_psel_q;
  logic                 dn_penable_q;
  logic [ADDR_W-1:0]    dn_paddr_q;
  logic [DATA_W-1:0]    dn_pwdata_q;
  logic                 up_pready_q;
  logic                 up_pslverr_q;
  logic [DATA_W-1:0]    up_prdata_q;
  logic [DATA_W-1:0]    rd_slice;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (up_psel[i]) sel_idx = IDX_W'(i);
    end
  end

  assign start    = (state_q == ST_IDLE) && (|up_psel) && !up_penable;
  assign rd_slice = dn_prdata[int'(idx_q)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      err_q        <= 1'b0;
      blk_q        <= 1'b0;
      attr_q       <= '0;
      dn_psel_q    <= '0;
      dn_penable_q <= 1'b0;
      dn_paddr_q   <= '0;
      dn_pwdata_q  <= '0;
      up_pready_q  <= 1'b0;
      up_pslverr_q <= 1'b0;
      up_prdata_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            idx_q       <= sel_idx;
            err_q       <= cfg_err_resp;
            blk_q       <= blocked;
            attr_q      <= '{write: up_pwrite, secure: up_psecure,
                             unpriv: up_puser, size: up_psize};
            dn_paddr_q  <= up_paddr;
            dn_pwdata_q <= up_pwdata;
            if (blocked) begin
              state_q <= ST_HOLD1;
            end else begin
              dn_psel_q <= up_psel;
              state_q   <= ST_DSETUP;
            end
          end
        end
        ST_DSETUP: begin
          dn_penable_q <= 1'b1;
          state_q      <= ST_DACCESS;
        end
        ST_DACCESS: begin
          if (dn_pready[idx_q]) begin
            dn_psel_q    <= '0;
            dn_penable_q <= 1'b0;
            up_pready_q  <= 1'b1;
            up_pslverr_q <= dn_pslverr[idx_q];
            up_prdata_q  <= attr_q.write ? '0 : rd_slice;
            state_q      <= ST_RESP;
          end
        end
        ST_HOLD1: state_q <= ST_HOLD2;
        ST_HOLD2: begin
          up_pready_q  <= 1'b1;
          up_pslverr_q <= err_q;
          up_prdata_q  <= '0;
          state_q      <= ST_RESP;
        end
        ST_RESP: begin
          up_pready_q  <= 1'b0;
          up_pslverr_q <= 1'b0;
          up_prdata_q  <= '0;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign up_pready  = up_pready_q;
  assign up_pslverr = up_pslverr_q;
  assign up_prdata  = up_prdata_q;
  assign dn_psel    = dn_psel_q;
  assign dn_penable = dn_penable_q;
  assign dn_pwrite  = attr_q.write;
  assign dn_paddr   = dn_paddr_q;
  assign dn_pwdata  = dn_pwdata_q;
  assign dn_psize   = attr_q.size;
  assign dn_psecure = attr_q.secure;
  assign dn_puser   = attr_q.unpriv;

  // R8: at most one downstream port is selected
  p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_psel));

  // R8: the access phase follows a selected setup phase
  p_enable_after_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_penable) |-> ($past(dn_psel) != '0));

  // R7: a blocked transfer keeps the downstream side quiet
  p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD1 || state_q == ST_HOLD2) |-> (dn_psel == '0 && !dn_penable));

  // R7: ready is a single-cycle pulse
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    up_pready |=> !up_pready);

  // R6: a silent block answers with zero data and no error
  p_silent_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (up_pready && blk_q && !err_q) |-> (up_prdata == '0 && !up_pslverr));
endmodule

// File: rtl/secure_access_gate.sv
`timescale 1ns/1ps
module secure_access_gate #(
  parameter int                   NUM_PORTS   = 16,
  parameter int                   ADDR_W      = 32,
  parameter int                   DATA_W      = 64,
  parameter logic [NUM_PORTS-1:0] NONSEC_MASK = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        cfg_nonsec,
  input  logic [NUM_PORTS-1:0]        cfg_ap,
  input  logic                        cfg_err_resp,
  input  logic                        irq_en,
  input  logic                        irq_clr,
  input  logic [NUM_PORTS-1:0]        up_psel,
  input  logic                        up_penable,
  input  logic                        up_pwrite,
  input  logic [ADDR_W-1:0]           up_paddr,
  input  logic [DATA_W-1:0]           up_pwdata,
  input  logic [1:0]                  up_psize,
  input  logic                        up_psecure,
  input  logic                        up_puser,
  output logic [DATA_W-1:0]           up_prdata,
  output logic                        up_pready,
  output logic                        up_pslverr,
  output logic [NUM_PORTS-1:0]        dn_psel,
  output logic                        dn_penable,
  output logic                        dn_pwrite,
  output logic [ADDR_W-1:0]           dn_paddr,
  output logic [DATA_W-1:0]           dn_pwdata,
  output logic [1:0]                  dn_psize,
  output logic                        dn_psecure,
  output logic                        dn_puser,
  input  logic [NUM_PORTS*DATA_W-1:0] dn_prdata,
  input  logic [NUM_PORTS-1:0]        dn_pready,
  input  logic [NUM_PORTS-1:0]        dn_pslverr,
  output logic                        irq
);
  logic blocked;
  logic start;
  logic block_evt;

  sag_port_check #(
    .NUM_PORTS   (NUM_PORTS),
    .NONSEC_MASK (NONSEC_MASK)
  ) u_check (
    .sel_oh     (up_psel),
    .cfg_nonsec (cfg_nonsec),
    .cfg_ap     (cfg_ap),
    .secure     (up_psecure),
    .unpriv     (up_puser),
    .blocked    (blocked)
  );

  sag_sequencer #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .up_psel      (up_psel),
    .up_penable   (up_penable),
    .up_pwrite    (up_pwrite),
    .up_paddr     (up_paddr),
    .up_pwdata    (up_pwdata),
    .up_psize     (up_psize),
    .up_psecure   (up_psecure),
    .up_puser     (up_puser),
    .blocked      (blocked),
    .cfg_err_resp (cfg_err_resp),
    .start        (start),
    .up_prdata    (up_prdata),
    .up_pready    (up_pready),
    .up_pslverr   (up_pslverr),
    .dn_psel      (dn_psel),
    .dn_penable   (dn_penable),
    .dn_pwrite    (dn_pwrite),
    .dn_paddr     (dn_paddr),
    .dn_pwdata    (dn_pwdata),
    .dn_psize     (dn_psize),
    .dn_psecure   (dn_psecure),
    .dn_puser     (dn_puser),
    .dn_prdata    (dn_prdata),
    .dn_pready    (dn_pready),
    .dn_pslverr   (dn_pslverr)
  );

  assign block_evt = start & blocked;

  sag_irq_ctrl u_irq (
    .clk       (clk),
    .rst       (rst),
    .block_evt (block_evt),
    .irq_clr   (irq_clr),
    .irq_en    (irq_en),
    .irq       (irq)
  );
endmodule

// File: tb/secure_access_gate_bench.sv
`timescale 1ns/1ps
module secure_access_gate_bench;
  localparam int P  = 16;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [P-1:0] MASK = 16'h8001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [P-1:0]    cfg_nonsec = '0, cfg_ap = '0;
  logic            cfg_err_resp = 1'b0, irq_en = 1'b1, irq_clr = 1'b0;
  logic [P-1:0]    up_psel = '0;
  logic            up_penable = 1'b0, up_pwrite = 1'b0;
  logic [AW-1:0]   up_paddr = '0;
  logic [DW-1:0]   up_pwdata = '0;
  logic [1:0]      up_psize = '0;
  logic            up_psecure = 1'b0, up_puser = 1'b0;
  logic [DW-1:0]   up_prdata;
  logic            up_pready, up_pslverr;
  logic [P-1:0]    dn_psel;
  logic            dn_penable, dn_pwrite, dn_psecure, dn_puser;
  logic [AW-1:0]   dn_paddr;
  logic [DW-1:0]   dn_pwdata;
  logic [1:0]      dn_psize;
  logic [P*DW-1:0] dn_prdata;
  logic [P-1:0]    dn_pready, dn_pslverr;
  logic            irq;

  secure_access_gate #(.NUM_PORTS(P), .ADDR_W(AW), .DATA_W(DW), .NONSEC_MASK(MASK)) u_secure_access_gate (
    .clk(clk), .rst(rst), .cfg_nonsec(cfg_nonsec), .cfg_ap(cfg_ap),
    .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr),
    .up_psel(up_psel), .up_penable(up_penable), .up_pwrite(up_pwrite),
    .up_paddr(up_paddr), .up_pwdata(up_pwdata), .up_psize(up_psize),
    .up_psecure(up_psecure), .up_puser(up_puser), .up_prdata(up_prdata),
    .up_pready(up_pready), .up_pslverr(up_pslverr), .dn_psel(dn_psel),
    .dn_penable(dn_penable), .dn_pwrite(dn_pwrite), .dn_paddr(dn_paddr),
    .dn_pwdata(dn_pwdata), .dn_psize(dn_psize), .dn_psecure(dn_psecure),
    .dn_puser(dn_puser), .dn_prdata(dn_prdata), .dn_pready(dn_pready),
    .dn_pslverr(dn_pslverr), .irq(irq));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- downstream responder model ----
  logic [DW-1:0] mem [P];
  int            wcnt = 0, wait_cfg = 0, fwd_cnt = 0, last_port = -1;
  logic [P-1:0]  err_mask = '0;
  logic [AW-1:0] last_addr;
  logic [1:0]    last_size;
  logic          last_sec, last_user;

  initial for (int i = 0; i < P; i++) mem[i] = '0;

  always_comb for (int i = 0; i < P; i++) dn_prdata[i*DW +: DW] = mem[i];
  assign dn_pready  = (dn_penable && wcnt == wait_cfg) ? dn_psel : '0;
  assign dn_pslverr = dn_psel & err_mask;

  always @(posedge clk) begin
    if (dn_penable && dn_pready != '0) begin
      for (int i = 0; i < P; i++) if (dn_pready[i]) begin
        last_port <= i;
        if (dn_pwrite) mem[i] <= dn_pwdata;
      end
      last_addr <= dn_paddr; last_size <= dn_psize;
      last_sec  <= dn_psecure; last_user <= dn_puser;
      fwd_cnt   <= fwd_cnt + 1;
    end
    if (!dn_penable || dn_pready != '0) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  // ---- behavioural interrupt model, compared every clock ----
  bit m_stat = 1'b0, m_blk = 1'b0, blk_active = 1'b0, mon_on = 1'b0;

  always @(posedge clk) begin
    if (rst) m_stat <= 1'b0;
    else if (irq_clr) m_stat <= 1'b0;
    else if (up_psel != '0 && !up_penable && m_blk) m_stat <= 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (mon_on && !done) begin
      chk(irq === (m_stat & irq_en), "R9 irq vs model", 64'(irq), 64'(m_stat & irq_en));
      if (blk_active)
        chk(dn_psel == '0 && !dn_penable, "R7 blocked select quiet", 64'(dn_psel), 64'd0);
    end
  end

  function automatic bit exp_block(int p, bit sec, bit usr);
    return ((MASK[p] == 1'b0) && (sec == cfg_nonsec[p])) || (usr && !cfg_ap[p]);
  endfunction

  task automatic do_acc(input int p, input bit wr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input logic [1:0] sz,
                        input bit sec, input bit usr,
                        output logic [DW-1:0] rd, output bit err, output int lat);
    @(negedge clk);
    m_blk = exp_block(p, sec, usr);
    blk_active = m_blk;
    up_psel = P'(1) << p; up_penable = 1'b0; up_pwrite = wr; up_paddr = addr;
    up_pwdata = wd; up_psize = sz; up_psecure = sec; up_puser = usr;
    @(negedge clk);
    up_penable = 1'b1;
    lat = 1;
    while (1) begin
      @(negedge clk);
      lat++;
      if (up_pready || lat > 40) break;
    end
    rd = up_prdata; err = up_pslverr;
    @(posedge clk);
    #1;
    up_psel = '0; up_penable = 1'b0; blk_active = 1'b0;
  endtask

  logic [DW-1:0] rd;
  bit            err;
  int            lat, f0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(!up_pready && !up_pslverr, "R1 upstream idle", {62'd0, up_pready, up_pslverr}, 64'd0);
    chk(dn_psel == '0 && !dn_penable, "R1 downstream idle", 64'(dn_psel), 64'd0);
    chk(!irq, "R1 irq low", 64'(irq), 64'd0);
    mon_on = 1'b1;

    // R1 silent mode after reset (cfg_err_resp low), port 3 secure, secure privileged write
    do_acc(3, 1, 32'h1234, 64'hA5A5_0001_0202_0303, 2'd3, 1, 0, rd, err, lat);
    chk(!err, "R8 permitted write ok", 64'(err), 0);
    chk(lat == 3, "R8 zero-wait latency", 64'(lat), 3);
    chk(last_port == 3 && last_addr == 32'h1234 && last_size == 2'd3 && last_sec && !last_user,
        "R8 attributes forwarded", 64'(last_addr), 64'h1234);
    chk(mem[3] == 64'hA5A5_0001_0202_0303, "R8 write data forwarded", mem[3], 64'hA5A5_0001_0202_0303);
    wait_cfg = 2;
    do_acc(3, 0, 32'h1238, '0, 2'd2, 1, 0, rd, err, lat);
    chk(rd == 64'hA5A5_0001_0202_0303, "R8 read data returned", rd, 64'hA5A5_0001_0202_0303);
    chk(lat == 5, "R8 wait-state latency", 64'(lat), 5);
    wait_cfg = 0;
    err_mask = P'(1) << 3;
    do_acc(3, 0, 32'h10, '0, 2'd0, 1, 0, rd, err, lat);
    chk(err, "R8 downstream error returned", 64'(err), 1);
    err_mask = '0;

    // R2/R5 non-secure to secure port, error mode
    cfg_err_resp = 1'b1;
    f0 = fwd_cnt;
    do_acc(3, 0, 32'h20, '0, 2'd2, 0, 0, rd, err, lat);
    chk(err, "R5 error response", 64'(err), 1);
    chk(lat == 3, "R7 blocked latency", 64'(lat), 3);
    chk(fwd_cnt == f0, "R2 nonsecure to secure port blocked", 64'(fwd_cnt), 64'(f0));
    @(negedge clk); #1;
    chk(irq, "R9 irq raised", 64'(irq), 1);

    // R2/R6 secure access to non-secure port, silent mode
    cfg_err_resp = 1'b0;
    cfg_nonsec[5] = 1'b1;
    do_acc(5, 1, 32'h40, 64'h1111_2222, 2'd2, 0, 0, rd, err, lat);
    chk(!err && mem[5] == 64'h1111_2222, "R2 nonsecure port takes nonsecure", mem[5], 64'h1111_2222);
    f0 = fwd_cnt;
    do_acc(5, 1, 32'h40, 64'hDEAD_BEEF, 2'd2, 1, 0, rd, err, lat);
    chk(!err && fwd_cnt == f0, "R6 blocked write silent", 64'(fwd_cnt), 64'(f0));
    do_acc(5, 0, 32'h40, '0, 2'd2, 1, 0, rd, err, lat);
    chk(rd == 0 && !err, "R6 blocked read zero", rd, 0);
    do_acc(5, 0, 32'h40, '0, 2'd2, 0, 0, rd, err, lat);
    chk(rd == 64'h1111_2222, "R6 blocked write left port unchanged", rd, 64'h1111_2222);

    // R3 masked ports ignore security setting
    f0 = fwd_cnt;
    do_acc(0, 0, 32'h80, '0, 2'd1, 0, 0, rd, err, lat);
    do_acc(0, 0, 32'h80, '0, 2'd1, 1, 0, rd, err, lat);
    cfg_nonsec[15] = 1'b1;
    do_acc(15, 0, 32'h84, '0, 2'd1, 1, 0, rd, err, lat);
    chk(fwd_cnt == f0 + 3, "R3 mask waives security", 64'(fwd_cnt), 64'(f0 + 3));

    // R4 privilege check
    f0 = fwd_cnt;
    do_acc(3, 0, 32'h90, '0, 2'd2, 1, 1, rd, err, lat);
    do_acc(0, 0, 32'h90, '0, 2'd2, 1, 1, rd, err, lat);
    chk(fwd_cnt == f0, "R4 unprivileged blocked incl masked", 64'(fwd_cnt), 64'(f0));
    cfg_ap[3] = 1'b1;
    do_acc(3, 0, 32'h94, '0, 2'd2, 1, 1, rd, err, lat);
    chk(fwd_cnt == f0 + 1 && last_user, "R4 unprivileged allowed", 64'(fwd_cnt), 64'(f0 + 1));

    // R9 enable gating
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk); #1;
    chk(!irq, "R9 irq masked by enable", 64'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk); #1;
    chk(irq, "R9 status sticky", 64'(irq), 1);

    // R10 clear, and clear coinciding with a blocked setup
    irq_clr = 1'b1;
    @(negedge clk); #1;
    chk(!irq, "R10 clear drops irq", 64'(irq), 0);
    do_acc(3, 0, 32'hA0, '0, 2'd2, 0, 0, rd, err, lat);
    irq_clr = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(!irq, "R10 block during clear ignored", 64'(irq), 0);

    // R11 configuration sampled at setup edge
    f0 = fwd_cnt;
    fork
      do_acc(3, 0, 32'hB0, '0, 2'd2, 1, 0, rd, err, lat);
      begin @(negedge clk); @(negedge clk); cfg_nonsec[3] = 1'b1; end
    join
    chk(fwd_cnt == f0 + 1 && !err, "R11 mid-transfer change ignored", 64'(fwd_cnt), 64'(f0 + 1));
    do_acc(3, 0, 32'hB0, '0, 2'd2, 1, 0, rd, err, lat);
    chk(fwd_cnt == f0 + 1, "R11 change applies to next", 64'(fwd_cnt), 64'(f0 + 1));
    fork
      do_acc(3, 0, 32'hB4, '0, 2'd2, 1, 0, rd, err, lat);
      begin @(negedge clk); @(negedge clk); cfg_err_resp = 1'b1; end
    join
    chk(!err, "R11 response mode sampled at start", 64'(err), 0);
    do_acc(3, 0, 32'hB4, '0, 2'd2, 1, 0, rd, err, lat);
    chk(err, "R11 new response mode next transfer", 64'(err), 1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule